// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM built so that a shared data bus never sits idle when traffic switches between reads and writes. On each enabled clock edge the block samples an address and its control lines. The data transfer for that command happens in the next clock cycle. Write commands and read commands can therefore be issued on consecutive edges with no gap.

Read data is flow-through: the word comes straight from the array during its data cycle and passes through no output register. Writes are masked per 9-bit byte lane. A built-in burst counter produces further beats from one loaded address, in either linear or interleaved order. A clock-hold input freezes the whole pipeline. The 36-bit bidirectional bus is split into an input, an output and a drive-enable, so a pad ring or a bench can join them.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded on edge t (`adv_ld`=0, all chip selects active, `we_n`=1) drives the word at that address on `dq_out`, with `dq_oe`=1, during the cycle from edge t to edge t+1.
- R2: Reads and writes alternate on consecutive edges with no idle cycle. A read loaded on the edge that ends a write's data cycle, to the same address, returns the newly written word.
- R3: While `cke_n`=1, every synchronous input is ignored and the pipeline holds its state, so `dq_out` and `dq_oe` keep their values.
- R4: A load with any chip select inactive starts no operation. The active levels are `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A data phase already pending still completes.
- R5: `dq_oe` is 0 in the cycle after a deselect load and in the cycle after a write load.
- R6: `oe_n`=1 forces `dq_oe` to 0 at once, between clock edges, whatever the pipeline state.
- R7: In a write data phase, bit i of `lane_we_n` (sampled with the command) low lets bus bits [9i+8:9i] replace the stored lane. A lane whose bit is high keeps its old contents.
- R8: With `burst_lin`=1 at load, advance beat k (0..3) addresses the word whose low two address bits are (base + k) mod 4. The upper bits stay unchanged.
- R9: With `burst_lin`=0 at load, advance beat k addresses the word whose low two address bits are base XOR k.
- R10: An advance (`adv_ld`=1) repeats the operation type of the loaded burst. The beats of a write burst keep the bus released, and the beats of a read burst drive it.
- R11: During and right after reset no operation is pending and `dq_oe` is 0.
- R12: An advance issued while no burst is active (after a deselect) starts nothing and leaves the bus released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the pipeline |
| cke_n | input | 1 | Clock hold, active low enable |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read (sampled on load) |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| burst_lin | input | 1 | 1 = linear, 0 = interleaved burst order |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Bus input (write data) |
| dq_out | output | LANES*LANE_W | Bus output (flow-through read data) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench fills the whole array and reads it back, then alternates writes and same-address reads under all sixteen lane masks. A design that registered its read output would return stale data on that read, and one that decoded lanes wrongly would corrupt neighbouring bits. Every start offset of a four-beat burst is tried in both orders, where a wrong wrap or a swapped order would place beats at the wrong words. Holds placed over pending reads and writes, deselects that arrive with a data phase in flight, advances issued after a deselect, and toggles of the output enable in mid-cycle expose a pipeline that slips, drops a transfer or drives the bus when it must not.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   // kind of data phase held in the pipeline
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } ph_kind_e;

endpackage

// File: rtl/zbt_ctl.sv
// Command stage: captures the command and owns the burst counter.
module zbt_ctl
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              sel,
   input  logic              we_n,
   input  logic              adv_ld,
   input  logic              burst_lin,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr,
   output ph_kind_e          ph_kind,
   output logic [ADDR_W-1:0] ph_base,
   output logic [CNT_W-1:0]  ph_cnt,
   output logic              ph_lin,
   output logic [LANES-1:0]  ph_lanes_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_kind    <= PH_IDLE;
         ph_base    <= '0;
         ph_cnt     <= '0;
         ph_lin     <= 1'b0;
         ph_lanes_n <= '1;
      end else if (!cke_n) begin
         ph_lanes_n <= lane_we_n;
         if (!adv_ld) begin
            if (sel) begin
               ph_kind <= we_n ? PH_READ : PH_WRITE;
               ph_base <= addr;
               ph_cnt  <= '0;
               ph_lin  <= burst_lin;
            end else begin
               ph_kind <= PH_IDLE;
            end
         end else if (ph_kind != PH_IDLE) begin
            ph_cnt <= ph_cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/zbt_burst.sv
// Beat address generation: linear or interleaved offset in the low bits.
module zbt_burst #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              lin,
   output logic [ADDR_W-1:0] beat_addr
);

   logic [CNT_W-1:0] low;

   always_comb begin
      if (lin) low = base[CNT_W-1:0] + cnt;
      else     low = base[CNT_W-1:0] ^ cnt;
   end

   generate
      if (ADDR_W > CNT_W) begin : g_upper
         assign beat_addr = {base[ADDR_W-1:CNT_W], low};
      end else begin : g_whole
         assign beat_addr = low;
      end
   endgenerate

endmodule

// File: rtl/zbt_array.sv
// Storage split into independently written lanes; asynchronous read.
module zbt_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        lane_en,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en && lane_en[i])
               mem[waddr] <= wdata[i*LANE_W +: LANE_W];
         end

         assign rdata[i*LANE_W +: LANE_W] = mem[waddr];
      end
   endgenerate

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int LANE_W    = 9,
   parameter int BURST_LEN = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    we_n,
   input  logic                    adv_ld,
   input  logic                    burst_lin,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;
   localparam int CNT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   // elaboration checks on the configuration
   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("zbt_sram: BURST_LEN must be a power of two of at least 2");
      end
      if (CNT_W > ADDR_W) begin : g_bad_addr
         $error("zbt_sram: address narrower than the burst counter");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("zbt_sram: lane count and width must be positive");
      end
   endgenerate

   ph_kind_e          ph_kind;
   logic [ADDR_W-1:0] ph_base;
   logic [CNT_W-1:0]  ph_cnt;
   logic              ph_lin;
   logic [LANES-1:0]  ph_lanes_n;
   logic [ADDR_W-1:0] beat_addr;
   logic [DATA_W-1:0] rdata;
   logic              sel;
   logic              wr_en;

   assign sel = !cs1_n && cs2 && !cs3_n;

   zbt_ctl #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .CNT_W  (CNT_W)
   ) i_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke_n      (cke_n),
      .sel        (sel),
      .we_n       (we_n),
      .adv_ld     (adv_ld),
      .burst_lin  (burst_lin),
      .lane_we_n  (lane_we_n),
      .addr       (addr),
      .ph_kind    (ph_kind),
      .ph_base    (ph_base),
      .ph_cnt     (ph_cnt),
      .ph_lin     (ph_lin),
      .ph_lanes_n (ph_lanes_n)
   );

   zbt_burst #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) i_burst (
      .base      (ph_base),
      .cnt       (ph_cnt),
      .lin       (ph_lin),
      .beat_addr (beat_addr)
   );

   // write lands on the enabled edge that closes its data cycle
   assign wr_en = !cke_n && (ph_kind == PH_WRITE);

   zbt_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_array (
      .clk     (clk),
      .wr_en   (wr_en),
      .lane_en (~ph_lanes_n),
      .waddr   (beat_addr),
      .wdata   (dq_in),
      .rdata   (rdata)
   );

   assign dq_out = rdata;
   assign dq_oe  = (ph_kind == PH_READ) && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              we_n,
   input logic              adv_ld,
   input logic              oe_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   logic sel;
   assign sel = !cs1_n && cs2 && !cs3_n;

   a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> $stable(dq_out));

   a_r3_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_n && !oe_n) |=> (oe_n || $stable(dq_oe)));

   a_r5_write_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && sel && !we_n) |=> !dq_oe);

   a_r4_desel_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && !sel) |=> !dq_oe);

   a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && sel && we_n) |=> (oe_n || dq_oe));

   a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(LANES * LANE_W)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cke_n  (cke_n),
   .cs1_n  (cs1_n),
   .cs2    (cs2),
   .cs3_n  (cs3_n),
   .we_n   (we_n),
   .adv_ld (adv_ld),
   .oe_n   (oe_n),
   .dq_out (dq_out),
   .dq_oe  (dq_oe)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_n = 1'b0;
   logic        cs1_n = 1'b1;
   logic        cs2 = 1'b1;
   logic        cs3_n = 1'b0;
   logic        we_n = 1'b1;
   logic        adv_ld = 1'b0;
   logic        burst_lin = 1'b0;
   logic [3:0]  lane_we_n = 4'hF;
   logic        oe_n = 1'b0;
   logic [5:0]  addr = '0;
   logic [35:0] dq_in = '0;
   logic [35:0] dq_out;
   logic        dq_oe;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;
   logic [35:0] ref_m [64];

   always #2.5 clk = ~clk;

   zbt_sram i_zbt_sram (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .we_n(we_n), .adv_ld(adv_ld), .burst_lin(burst_lin),
      .lane_we_n(lane_we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [35:0] pat(int a);
      return (36'(a) * 36'h01F3D5B79) ^ 36'hA5C3C96E1;
   endfunction

   function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] m_n);
      logic [35:0] r = old;
      for (int i = 0; i < 4; i++)
         if (!m_n[i]) r[i*9 +: 9] = nw[i*9 +: 9];
      return r;
   endfunction

   task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_load(bit wr, int a, logic [3:0] m_n, bit lin);
      cke_n = 0; adv_ld = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
      we_n = !wr; addr = 6'(a); lane_we_n = m_n; burst_lin = lin;
   endtask

   task automatic set_adv(logic [3:0] m_n);
      cke_n = 0; adv_ld = 1; lane_we_n = m_n;
   endtask

   task automatic set_desel();
      cke_n = 0; adv_ld = 0; cs1_n = 1; cs2 = 1; cs3_n = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      // R11: reset
      set_desel();
      repeat (3) tick();
      chk("R11 oe in reset", 36'(dq_oe), 36'(0));
      rst_n = 1;
      tick();
      chk("R11 oe after reset", 36'(dq_oe), 36'(0));

      // fill whole array, writes back to back
      for (int k = 0; k <= 64; k++) begin
         if (k < 64) set_load(1, k, 4'h0, 0); else set_desel();
         dq_in = (k > 0) ? pat(k - 1) : '0;
         tick();
         if (k < 64) chk("R5 write release", 36'(dq_oe), 36'(0));
      end
      for (int k = 0; k < 64; k++) ref_m[k] = pat(k);

      // read it all back
      for (int k = 0; k < 64; k++) begin
         set_load(0, k, 4'hF, 0);
         dq_in = '0;
         tick();
         chk("R1 read drive", 36'(dq_oe), 36'(1));
         chk("R1 read data", dq_out, ref_m[k]);
      end
      set_desel();
      tick();
      chk("R5 desel release", 36'(dq_oe), 36'(0));

      // alternating write / same-address read under every lane mask
      for (int m = 0; m < 16; m++) begin
         int a = (m * 5) & 63;
         logic [35:0] nd = ~pat(a + 100);
         set_load(1, a, 4'(m), 0);
         tick();
         chk("R5 write load", 36'(dq_oe), 36'(0));
         set_load(0, a, 4'hF, 0);
         dq_in = nd;
         tick();
         ref_m[a] = merge(ref_m[a], nd, 4'(m));
         chk("R2 turnaround drive", 36'(dq_oe), 36'(1));
         chk("R7 lane merge", dq_out, ref_m[a]);
      end

      // R3: hold over a read, inputs wiggle
      set_load(0, 7, 4'hF, 0);
      tick();
      cke_n = 1; adv_ld = 1; we_n = 0; addr = 6'd9; dq_in = 36'h123456789;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R3 hold data", dq_out, ref_m[7]);
         chk("R3 hold drive", 36'(dq_oe), 36'(1));
      end
      // hold over a pending write
      set_load(1, 9, 4'h0, 0);
      tick();
      cke_n = 1; adv_ld = 0; we_n = 1;
      tick();
      tick();
      chk("R3 hold write phase", 36'(dq_oe), 36'(0));
      set_load(0, 9, 4'hF, 0);
      dq_in = 36'h0BADC0DE5;
      tick();
      ref_m[9] = 36'h0BADC0DE5;
      chk("R3 write after hold", dq_out, ref_m[9]);

      // R4: each chip select inactive blocks a new write
      for (int e = 0; e < 3; e++) begin
         set_load(1, 20 + e, 4'h0, 0);
         if (e == 0) cs1_n = 1;
         if (e == 1) cs2 = 0;
         if (e == 2) cs3_n = 1;
         tick();
         chk("R4 no op drive", 36'(dq_oe), 36'(0));
         set_load(0, 20 + e, 4'hF, 0);
         dq_in = 36'hFFFFFFFFF;
         tick();
         chk("R4 no op data", dq_out, ref_m[20 + e]);
      end
      // pending write completes through a deselect
      set_load(1, 30, 4'h0, 0);
      tick();
      set_desel();
      dq_in = 36'h600DF00D1;
      tick();
      chk("R4 desel after write", 36'(dq_oe), 36'(0));
      set_load(0, 30, 4'hF, 0);
      tick();
      ref_m[30] = 36'h600DF00D1;
      chk("R4 pending write done", dq_out, ref_m[30]);
      // pending read completes, then bus released
      set_load(0, 31, 4'hF, 0);
      tick();
      set_desel();
      chk("R4 pending read data", dq_out, ref_m[31]);
      chk("R4 pending read drive", 36'(dq_oe), 36'(1));
      tick();
      chk("R5 desel after read", 36'(dq_oe), 36'(0));

      // R12: advance with no burst active
      set_adv(4'h0);
      we_n = 1;
      tick();
      chk("R12 adv idle", 36'(dq_oe), 36'(0));
      we_n = 0;
      dq_in = 36'h0DEADBEEF;
      tick();
      chk("R12 adv idle again", 36'(dq_oe), 36'(0));
      set_load(0, 31, 4'hF, 0);
      dq_in = '0;
      tick();
      chk("R12 no write", dq_out, ref_m[31]);

      // R6: asynchronous output enable
      set_load(0, 5, 4'hF, 0);
      tick();
      oe_n = 1;
      #1;
      chk("R6 oe off", 36'(dq_oe), 36'(0));
      oe_n = 0;
      #1;
      chk("R6 oe on", 36'(dq_oe), 36'(1));

      // R8 / R9 / R10: bursts from every start offset in both orders
      for (int lin = 0; lin < 2; lin++) begin
         for (int b = 0; b < 4; b++) begin
            int region = 40 + lin * 8;
            string tag = lin ? "R8" : "R9";
            set_load(1, region + b, 4'h0, lin[0]);
            tick();
            for (int k = 0; k < 4; k++) begin
               int e = region + (lin ? ((b + k) & 3) : (b ^ k));
               logic [35:0] bd = pat(lin * 64 + b * 8 + k + 500);
               if (k < 3) set_adv(4'h0); else set_desel();
               dq_in = bd;
               tick();
               ref_m[e] = bd;
               chk("R10 write burst release", 36'(dq_oe), 36'(0));
            end
            set_load(0, region + b, 4'hF, lin[0]);
            tick();
            for (int k = 0; k < 4; k++) begin
               int e = region + (lin ? ((b + k) & 3) : (b ^ k));
               chk(tag, dq_out, ref_m[e]);
               chk("R10 read burst drive", 36'(dq_oe), 36'(1));
               if (k < 3) set_adv(4'hF); else set_desel();
               tick();
            end
            chk("R5 after burst", 36'(dq_oe), 36'(0));
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule